// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds a small bank of debug breakpoint triggers and decides, for each memory or fetch access, whether one of them fires. Every trigger has a control word and a compare value. Each access presents an operation kind, the current privilege level, an address, a data word and a flag for 32-bit mode. The unit reports whether a trigger fired and which one. The result is registered, so it appears one clock after the access is presented.

Software-side logic loads the bank through a simple port. A select input names one trigger, and separate write strobes load its control word or its compare value. A trigger can restrict itself to some operations and to some privilege levels. It can compare either the address or the data word, using one of six compare modes. Adjacent triggers can be chained, so that a run of them must all match before the last one fires.

The action that follows a match is out of scope. So are register address decoding and the pipeline that produces the accesses.

Top module: `trig_match_unit`

## Requirements
- R1: The control word is 12 bits wide, with these fields:
  - bits 2:0 enable the operations. Bit 0 is execute (op code 0), bit 1 is store (op code 1) and bit 2 is load (op code 2).
  - bits 6:3 enable the privilege levels. Bit 3+p enables privilege code p, where U=0, S=1, H=2 and M=3.
  - bit 7 is chain.
  - bits 10:8 are the compare mode: 0 equal, 1 NAPOT, 2 greater-or-equal, 3 less-than, 4 mask-low, 5 mask-high.
  - bit 11 selects data instead of address.

  A strobe on the write port loads the control word or the compare value of the trigger named by the select input, on that clock edge. Reset clears every control word and value, so that no trigger is active and the output shows no hit.
- R2: A trigger takes no part when the enable bit of the current operation is clear.
- R3: A trigger takes no part when the enable bit of the current privilege level is clear.
- R4: With the select bit set, the data word is compared. With it clear, the address is compared.
- R5: When the 32-bit flag is high, the compared value is cut to its low 32 bits before comparison.
- R6: The equal mode, the greater-or-equal mode and the less-than mode each compare the value unsigned against the trigger value.
- R7: In NAPOT mode, the run of contiguous ones starting at bit 0 of the trigger value gives the number of low bits that are ignored. All bits above that run must be equal.
- R8: In mask-low mode, the upper half of the trigger value is a mask. The masked low half of the compared value must equal the masked low half of the trigger value. In mask-high mode, the upper half of the compared value, shifted down, is masked in the same way and compared with the low half of the trigger value.
- R9: A matching trigger with chain set never fires on its own. When every member of a chain matches, the chain-clear trigger that ends it is reported.
- R10: When a member of a chain fails, all remaining members of that chain are skipped, up to and including its first chain-clear trigger. The scan resumes after that trigger.
- R11: When several independent triggers match, the lowest index is reported.
- R12: No hit is reported when the access is not valid, or while a debug cause is pending. The hit result and the index appear on the clock after the access. The index reads 0 whenever there is no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 2 | Trigger index targeted by a configuration write |
| cfg_ctrl_we | input | 1 | Load the control word of the selected trigger |
| cfg_ctrl_wdata | input | 12 | Control word to load |
| cfg_val_we | input | 1 | Load the compare value of the selected trigger |
| cfg_val_wdata | input | 64 | Compare value to load |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_op | input | 2 | Operation: 0 execute, 1 store, 2 load |
| acc_priv | input | 2 | Privilege: 0 U, 1 S, 2 H, 3 M |
| acc_addr | input | 64 | Access address |
| acc_data | input | 64 | Access data word |
| acc_is32 | input | 1 | 32-bit mode flag |
| dbg_pending | input | 1 | A debug cause is already pending |
| hit_o | output | 1 | A trigger fired on the previous access |
| hit_idx_o | output | 2 | Index of the trigger that fired, 0 when there is no hit |

## Verification
Some behaviour is checked by the assertions on every cycle:
- A configuration write lands in the selected trigger.
- Reset leaves the control words clear.
- An invalid access, or one made while debug is pending, produces no hit.
- The index is zero without a hit.
- A reported trigger is always qualified and never has chain set.

Other behaviour only the directed scenarios can show. This covers the operation and privilege enables, the data/address select, the 32-bit cut, each compare mode with its boundary values, chain completion, skipping after a failed chain, and lowest-index priority.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int CTRL_W = 12;

    typedef enum logic [2:0] {
        CMP_EQ    = 3'd0,
        CMP_NAPOT = 3'd1,
        CMP_GE    = 3'd2,
        CMP_LT    = 3'd3,
        CMP_MLO   = 3'd4,
        CMP_MHI   = 3'd5
    } cmp_mode_e;

    typedef enum logic [1:0] {
        OP_EXEC  = 2'd0,
        OP_STORE = 2'd1,
        OP_LOAD  = 2'd2,
        OP_NONE  = 2'd3
    } acc_op_e;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_H = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    // Packed from the MSB down: bit 11 select, 10:8 mode, 7 chain, 6:3 priv, 2:0 op
    typedef struct packed {
        logic      sel_data;
        logic [2:0] mode;
        logic      chain;
        logic [3:0] priv_en;
        logic [2:0] op_en;
    } trig_ctrl_t;

    function automatic logic op_enabled(input logic [2:0] en, input logic [1:0] op);
        logic r;
        case (op)
            OP_EXEC:  r = en[0];
            OP_STORE: r = en[1];
            OP_LOAD:  r = en[2];
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
    import trig_pkg::*;
#(
    parameter int NUM_TRIG = 4,
    parameter int XLEN     = 64,
    localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] wr_sel,
    input  logic             ctrl_we,
    input  trig_ctrl_t       ctrl_wdata,
    input  logic             val_we,
    input  logic [XLEN-1:0]  val_wdata,
    output trig_ctrl_t       ctrl_o [NUM_TRIG],
    output logic [XLEN-1:0]  val_o  [NUM_TRIG]
);

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_entry
        trig_ctrl_t      ctrl_q;
        logic [XLEN-1:0] val_q;
        logic            hit_sel;

        assign hit_sel = (wr_sel == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q <= '0;
                val_q  <= '0;
            end else begin
                if (ctrl_we && hit_sel) ctrl_q <= ctrl_wdata;
                if (val_we && hit_sel)  val_q  <= val_wdata;
            end
        end

        assign ctrl_o[i] = ctrl_q;
        assign val_o[i]  = val_q;

        // R1: a control write lands in the selected entry on the next edge
        p_ctrl_write_r1: assert property (@(posedge clk) disable iff (rst)
            (ctrl_we && wr_sel == IDX_W'(i)) |=> (ctrl_q == $past(ctrl_wdata)));

        // R1: the entry comes out of reset with every enable clear
        p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (ctrl_q == '0));
    end

endmodule

// File: rtl/trig_cmp.sv
module trig_cmp
    import trig_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2:0]      op_en,
    input  logic [3:0]      priv_en,
    input  logic [2:0]      mode,
    input  logic            sel_data,
    input  logic [XLEN-1:0] tval,
    input  logic [1:0]      op,
    input  logic [1:0]      priv,
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] data,
    input  logic            is32,
    output logic            ok
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] raw_v;
    logic [XLEN-1:0] cut_mask;
    logic [XLEN-1:0] cmp_v;
    logic [XLEN-1:0] napot_ign;
    logic [XLEN-1:0] half_mask;
    logic            qual;
    logic            cmp_true;

    // 32-bit cut mask and the NAPOT ignore mask (run of ones from bit 0)
    always_comb begin
        logic run;
        run = 1'b1;
        for (int b = 0; b < XLEN; b++) begin
            cut_mask[b]  = (b < 32);
            run          = run & tval[b];
            napot_ign[b] = run;
        end
    end

    assign raw_v     = sel_data ? data : addr;
    assign cmp_v     = is32 ? (raw_v & cut_mask) : raw_v;
    assign half_mask = tval >> HALF;

    assign qual = op_enabled(op_en, op) && priv_en[priv];

    always_comb begin
        case (mode)
            CMP_EQ:    cmp_true = (cmp_v == tval);
            CMP_NAPOT: cmp_true = ((cmp_v & ~napot_ign) == (tval & ~napot_ign));
            CMP_GE:    cmp_true = (cmp_v >= tval);
            CMP_LT:    cmp_true = (cmp_v < tval);
            CMP_MLO:   cmp_true = ((cmp_v & half_mask) == (tval & half_mask));
            CMP_MHI:   cmp_true = (((cmp_v >> HALF) & half_mask) == (tval & half_mask));
            default:   cmp_true = 1'b0;
        endcase
    end

    assign ok = qual && cmp_true;

endmodule

// File: rtl/trig_resolve.sv
module trig_resolve #(
    parameter int NUM_TRIG = 4,
    localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                valid,
    input  logic                dbg_pending,
    input  logic [NUM_TRIG-1:0] chain,
    input  logic [NUM_TRIG-1:0] ok,
    output logic                hit,
    output logic [IDX_W-1:0]    idx
);

    logic             found;
    logic [IDX_W-1:0] found_idx;

    always_comb begin
        logic skip;
        found     = 1'b0;
        found_idx = '0;
        skip      = 1'b0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (!found) begin
                if (skip) begin
                    if (!chain[i]) skip = 1'b0;
                end else if (ok[i]) begin
                    if (!chain[i]) begin
                        found     = 1'b1;
                        found_idx = IDX_W'(i);
                    end
                end else if (chain[i]) begin
                    skip = 1'b1;
                end
            end
        end
    end

    assign hit = found && valid && !dbg_pending;
    assign idx = hit ? found_idx : '0;

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
    import trig_pkg::*;
#(
    parameter int NUM_TRIG = 4,
    parameter int XLEN     = 64,
    localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic              cfg_ctrl_we,
    input  logic [CTRL_W-1:0] cfg_ctrl_wdata,
    input  logic              cfg_val_we,
    input  logic [XLEN-1:0]   cfg_val_wdata,
    input  logic              acc_valid,
    input  logic [1:0]        acc_op,
    input  logic [1:0]        acc_priv,
    input  logic [XLEN-1:0]   acc_addr,
    input  logic [XLEN-1:0]   acc_data,
    input  logic              acc_is32,
    input  logic              dbg_pending,
    output logic              hit_o,
    output logic [IDX_W-1:0]  hit_idx_o
);

    trig_ctrl_t          ctrl [NUM_TRIG];
    logic [XLEN-1:0]     tval [NUM_TRIG];
    logic [NUM_TRIG-1:0] chain_v;
    logic [NUM_TRIG-1:0] ok_v;
    logic                hit_c;
    logic [IDX_W-1:0]    idx_c;
    logic                hit_q;
    logic [IDX_W-1:0]    idx_q;

    trig_cfg_bank #(.NUM_TRIG(NUM_TRIG), .XLEN(XLEN)) bank_i (
        .clk        (clk),
        .rst        (rst),
        .wr_sel     (cfg_sel),
        .ctrl_we    (cfg_ctrl_we),
        .ctrl_wdata (trig_ctrl_t'(cfg_ctrl_wdata)),
        .val_we     (cfg_val_we),
        .val_wdata  (cfg_val_wdata),
        .ctrl_o     (ctrl),
        .val_o      (tval)
    );

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_cmp
        assign chain_v[i] = ctrl[i].chain;

        trig_cmp #(.XLEN(XLEN)) cmp_i (
            .op_en    (ctrl[i].op_en),
            .priv_en  (ctrl[i].priv_en),
            .mode     (ctrl[i].mode),
            .sel_data (ctrl[i].sel_data),
            .tval     (tval[i]),
            .op       (acc_op),
            .priv     (acc_priv),
            .addr     (acc_addr),
            .data     (acc_data),
            .is32     (acc_is32),
            .ok       (ok_v[i])
        );
    end

    trig_resolve #(.NUM_TRIG(NUM_TRIG)) resolve_i (
        .valid       (acc_valid),
        .dbg_pending (dbg_pending),
        .chain       (chain_v),
        .ok          (ok_v),
        .hit         (hit_c),
        .idx         (idx_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end else begin
            hit_q <= hit_c;
            idx_q <= idx_c;
        end
    end

    assign hit_o     = hit_q;
    assign hit_idx_o = idx_q;

    // R12: a pending debug cause blocks every hit
    p_no_hit_debug_r12: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && dbg_pending) |=> !hit_o);

    // R12: no access, no hit
    p_no_hit_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !hit_o);

    // R12: index reads zero without a hit
    p_idx_zero_r12: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> (hit_idx_o == '0));

    // R9: the reported trigger matched and ends its chain
    p_fire_chain_end_r9: assert property (@(posedge clk) disable iff (rst)
        hit_c |-> (ok_v[idx_c] && !chain_v[idx_c]));

endmodule

// File: tb/trig_match_unit_tb_top.sv
`timescale 1ns/1ps
module trig_match_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_sel = '0;
    logic        cfg_ctrl_we = 1'b0;
    logic [11:0] cfg_ctrl_wdata = '0;
    logic        cfg_val_we = 1'b0;
    logic [63:0] cfg_val_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_op = '0;
    logic [1:0]  acc_priv = '0;
    logic [63:0] acc_addr = '0;
    logic [63:0] acc_data = '0;
    logic        acc_is32 = 1'b0;
    logic        dbg_pending = 1'b0;
    logic        hit_o;
    logic [1:0]  hit_idx_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    trig_match_unit dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_sel        (cfg_sel),
        .cfg_ctrl_we    (cfg_ctrl_we),
        .cfg_ctrl_wdata (cfg_ctrl_wdata),
        .cfg_val_we     (cfg_val_we),
        .cfg_val_wdata  (cfg_val_wdata),
        .acc_valid      (acc_valid),
        .acc_op         (acc_op),
        .acc_priv       (acc_priv),
        .acc_addr       (acc_addr),
        .acc_data       (acc_data),
        .acc_is32       (acc_is32),
        .dbg_pending    (dbg_pending),
        .hit_o          (hit_o),
        .hit_idx_o      (hit_idx_o)
    );

    localparam logic [2:0] EX = 3'b001, ST = 3'b010, LD = 3'b100;
    localparam logic [3:0] ALLP = 4'hF;

    function automatic logic [11:0] mk(input logic [2:0] ope, input logic [3:0] pe,
                                       input logic ch, input logic [2:0] md, input logic sd);
        return {sd, md, ch, pe, ope};
    endfunction

    task automatic check(input logic h, input logic [1:0] ix,
                         input logic eh, input logic [1:0] eix, input string tag);
        total++;
        if (h !== eh || ix !== eix) begin
            bad++;
            $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", tag, h, ix, eh, eix);
        end
    endtask

    task automatic wr_ctrl(input int i, input logic [11:0] c);
        @(negedge clk);
        cfg_sel = 2'(i); cfg_ctrl_wdata = c; cfg_ctrl_we = 1'b1;
        @(negedge clk);
        cfg_ctrl_we = 1'b0;
    endtask

    task automatic wr_val(input int i, input logic [63:0] v);
        @(negedge clk);
        cfg_sel = 2'(i); cfg_val_wdata = v; cfg_val_we = 1'b1;
        @(negedge clk);
        cfg_val_we = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) wr_ctrl(i, 12'h0);
    endtask

    task automatic probe(input logic [1:0] op, input logic [1:0] pv, input logic [63:0] a,
                         input logic [63:0] d, input logic i32, input logic dbg, input logic vld,
                         input logic eh, input logic [1:0] eix, input string tag);
        @(negedge clk);
        acc_op = op; acc_priv = pv; acc_addr = a; acc_data = d;
        acc_is32 = i32; dbg_pending = dbg; acc_valid = vld;
        @(posedge clk);
        #1;
        check(hit_o, hit_idx_o, eh, eix, tag);
        @(negedge clk);
        acc_valid = 1'b0; dbg_pending = 1'b0;
    endtask

    task automatic t_reset();
        check(hit_o, hit_idx_o, 1'b0, 2'd0, "R1 reset output");
        probe(2'd0, 2'd3, 64'h0, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, "R1 reset disables triggers");
    endtask

    task automatic t_ops();
        clear_all();
        wr_val(0, 64'h1000);
        wr_ctrl(0, mk(EX, ALLP, 1'b0, 3'd0, 1'b0));
        probe(2'd0, 2'd3, 64'h1000, 0, 0, 0, 1, 1'b1, 2'd0, "R2 execute enabled");
        probe(2'd1, 2'd3, 64'h1000, 0, 0, 0, 1, 1'b0, 2'd0, "R2 store disabled");
        wr_ctrl(0, mk(LD, ALLP, 1'b0, 3'd0, 1'b0));
        probe(2'd2, 2'd3, 64'h1000, 0, 0, 0, 1, 1'b1, 2'd0, "R2 load enabled");
        probe(2'd0, 2'd3, 64'h1000, 0, 0, 0, 1, 1'b0, 2'd0, "R2 execute disabled");
    endtask

    task automatic t_priv();
        wr_ctrl(0, mk(EX, 4'b1000, 1'b0, 3'd0, 1'b0));
        probe(2'd0, 2'd3, 64'h1000, 0, 0, 0, 1, 1'b1, 2'd0, "R3 M enabled");
        probe(2'd0, 2'd0, 64'h1000, 0, 0, 0, 1, 1'b0, 2'd0, "R3 U disabled");
        wr_ctrl(0, mk(EX, 4'b0010, 1'b0, 3'd0, 1'b0));
        probe(2'd0, 2'd1, 64'h1000, 0, 0, 0, 1, 1'b1, 2'd0, "R3 S enabled");
    endtask

    task automatic t_select();
        wr_val(0, 64'hABCD);
        wr_ctrl(0, mk(ST, ALLP, 1'b0, 3'd0, 1'b1));
        probe(2'd1, 2'd0, 64'hABCD, 64'h0, 0, 0, 1, 1'b0, 2'd0, "R4 address ignored");
        probe(2'd1, 2'd0, 64'h0, 64'hABCD, 0, 0, 1, 1'b1, 2'd0, "R4 data compared");
    endtask

    task automatic t_cut32();
        wr_val(0, 64'h0000_0000_1234_5678);
        wr_ctrl(0, mk(EX, ALLP, 1'b0, 3'd0, 1'b0));
        probe(2'd0, 2'd3, 64'hFFFF_FFFF_1234_5678, 0, 1, 0, 1, 1'b1, 2'd0, "R5 32-bit cut");
        probe(2'd0, 2'd3, 64'hFFFF_FFFF_1234_5678, 0, 0, 0, 1, 1'b0, 2'd0, "R5 64-bit full");
    endtask

    task automatic t_ordered();
        wr_val(0, 64'h100);
        wr_ctrl(0, mk(EX, ALLP, 1'b0, 3'd2, 1'b0));
        probe(2'd0, 2'd3, 64'h100, 0, 0, 0, 1, 1'b1, 2'd0, "R6 GE equal");
        probe(2'd0, 2'd3, 64'hFF, 0, 0, 0, 1, 1'b0, 2'd0, "R6 GE below");
        probe(2'd0, 2'd3, 64'h8000_0000_0000_0000, 0, 0, 0, 1, 1'b1, 2'd0, "R6 GE unsigned");
        wr_ctrl(0, mk(EX, ALLP, 1'b0, 3'd3, 1'b0));
        probe(2'd0, 2'd3, 64'hFF, 0, 0, 0, 1, 1'b1, 2'd0, "R6 LT below");
        probe(2'd0, 2'd3, 64'h100, 0, 0, 0, 1, 1'b0, 2'd0, "R6 LT equal");
        wr_ctrl(0, mk(EX, ALLP, 1'b0, 3'd0, 1'b0));
        probe(2'd0, 2'd3, 64'h101, 0, 0, 0, 1, 1'b0, 2'd0, "R6 EQ differ");
    endtask

    task automatic t_napot();
        wr_val(0, 64'h1007);
        wr_ctrl(0, mk(EX, ALLP, 1'b0, 3'd1, 1'b0));
        probe(2'd0, 2'd3, 64'h1005, 0, 0, 0, 1, 1'b1, 2'd0, "R7 napot inside");
        probe(2'd0, 2'd3, 64'h1000, 0, 0, 0, 1, 1'b1, 2'd0, "R7 napot base");
        probe(2'd0, 2'd3, 64'h1008, 0, 0, 0, 1, 1'b0, 2'd0, "R7 napot outside");
    endtask

    task automatic t_mask();
        wr_val(0, {32'h0000_00FF, 32'h0000_0012});
        wr_ctrl(0, mk(EX, ALLP, 1'b0, 3'd4, 1'b0));
        probe(2'd0, 2'd3, 64'hAB12, 0, 0, 0, 1, 1'b1, 2'd0, "R8 mask-low match");
        probe(2'd0, 2'd3, 64'hAB13, 0, 0, 0, 1, 1'b0, 2'd0, "R8 mask-low miss");
        wr_ctrl(0, mk(EX, ALLP, 1'b0, 3'd5, 1'b0));
        probe(2'd0, 2'd3, 64'h0000_AB12_0000_0000, 0, 0, 0, 1, 1'b1, 2'd0, "R8 mask-high match");
        probe(2'd0, 2'd3, 64'h0000_0013_0000_0012, 0, 0, 0, 1, 1'b0, 2'd0, "R8 mask-high miss");
    endtask

    task automatic t_chain();
        clear_all();
        wr_val(0, 64'h2000);
        wr_val(1, 64'h55);
        wr_ctrl(0, mk(ST, ALLP, 1'b1, 3'd0, 1'b0));
        wr_ctrl(1, mk(ST, ALLP, 1'b0, 3'd0, 1'b1));
        probe(2'd1, 2'd0, 64'h2000, 64'h55, 0, 0, 1, 1'b1, 2'd1, "R9 full chain");
        probe(2'd1, 2'd0, 64'h2000, 64'h0, 0, 0, 1, 1'b0, 2'd0, "R9 chained alone");
    endtask

    task automatic t_skip();
        clear_all();
        wr_val(0, 64'h3000);
        wr_val(1, 64'h4000);
        wr_val(2, 64'h4000);
        wr_ctrl(0, mk(EX, ALLP, 1'b1, 3'd0, 1'b0));
        wr_ctrl(1, mk(EX, ALLP, 1'b0, 3'd0, 1'b0));
        wr_ctrl(2, mk(EX, ALLP, 1'b0, 3'd0, 1'b0));
        probe(2'd0, 2'd3, 64'h4000, 0, 0, 0, 1, 1'b1, 2'd2, "R10 skip after failed chain");
    endtask

    task automatic t_priority();
        clear_all();
        wr_val(1, 64'h5000);
        wr_val(3, 64'h5000);
        wr_ctrl(1, mk(LD, ALLP, 1'b0, 3'd0, 1'b0));
        wr_ctrl(3, mk(LD, ALLP, 1'b0, 3'd0, 1'b0));
        probe(2'd2, 2'd2, 64'h5000, 0, 0, 0, 1, 1'b1, 2'd1, "R11 lowest index");
        wr_ctrl(1, 12'h0);
        probe(2'd2, 2'd2, 64'h5000, 0, 0, 0, 1, 1'b1, 2'd3, "R11 next index");
    endtask

    task automatic t_gate();
        probe(2'd2, 2'd2, 64'h5000, 0, 0, 1, 1, 1'b0, 2'd0, "R12 debug pending");
        probe(2'd2, 2'd2, 64'h5000, 0, 0, 0, 0, 1'b0, 2'd0, "R12 not valid");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ops();
        t_priv();
        t_select();
        t_cut32();
        t_ordered();
        t_napot();
        t_mask();
        t_chain();
        t_skip();
        t_priority();
        t_gate();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: hit=%0b idx=%0d expected run to end", hit_o, hit_idx_o);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule